// File: doc/BRIEF.md
# Pipelined CRC Receive Checker

This block checks a stream of 16-bit words in which each block ends with a 16-bit checksum word. It folds every accepted word into a CRC-CCITT state (generator x^16 + x^12 + x^5 + 1, all-ones start value). After the checksum word has been folded in, a clean block leaves a zero residue. Any other residue raises a one-cycle error pulse at a fixed point in time after the checksum word.

The update is split over two register stages to keep the XOR depth per stage short. The first stage forms the term that depends only on the incoming word. The second stage combines that term with the running state. A block is opened by asserting the block-clear input. If the clear comes together with the block's first word, the second stage does not preset the state in a separate cycle. Instead it loads the data term XORed with the constant that an all-ones state would have contributed. This allows a new block to follow its predecessor's checksum word with no idle cycle.

The word input is a valid/ready stream. The checker never applies back-pressure: `in_ready` is held high, and a word is taken on every cycle in which `in_valid` is high. The block-clear input and the error output are plain control pins.

Top module: `crc_rx_checker`

## Requirements
- R1: The state advances per accepted word as next = ((state XOR word) * x^16) mod (x^16 + x^12 + x^5 + 1). State bit 15 is the highest coefficient, and word bit 15 is taken first.
- R2: A block made of data words followed by a checksum word, where the checksum equals the CRC of those data words from an all-ones start, produces no error pulse. This includes a block that is only a checksum word of value 0xFFFF.
- R3: When the residue after a checksum word is nonzero, `err_o` is high for exactly the one cycle that lies two cycles after the cycle in which that checksum word was accepted. `err_o` is low in every other cycle, and checksum words on consecutive cycles give pulses on consecutive cycles.
- R4: When `blk_clr` is high in the same cycle as a block's first word, the state is computed as if it had been all ones before that word, by using the constant 0x1D0F (all ones times x^16 mod the generator). This works even when the word directly follows the previous block's checksum word.
- R5: When `blk_clr` is high in a cycle with no valid word, the state is preset to all ones. A following block that starts without a clear is then checked correctly.
- R6: Cycles with `in_valid` low and `blk_clr` low leave the state unchanged, so idle gaps inside a block do not alter its outcome.
- R7: While `in_valid` is low, `in_data` and `in_last` have no effect. In particular, `in_last` high without `in_valid` never produces an error pulse.
- R8: `in_ready` is high in every cycle, including during reset.
- R9: Synchronous active-low reset clears `err_o` and presets the state to all ones, so the first block after reset may start without a clear.
- R10: Any corruption of a single bit or of several bits in the checksum word or in a data word gives a nonzero residue and therefore an error pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| blk_clr | input | 1 | Opens a new block: preset, or emulated preset when a word is present |
| in_valid | input | 1 | A word is present on `in_data` |
| in_ready | output | 1 | Always high; the checker never stalls the stream |
| in_data | input | W (16) | Data or checksum word |
| in_last | input | 1 | The current valid word is the block's checksum word |
| err_o | output | 1 | One-cycle pulse: the block that just ended failed its check |

## Verification
The bench builds the checker with its default parameters: a 16-bit word, generator 0x1021 and an all-ones start value. These are the values under which the all-ones restart constant is 0x1D0F and a correct block leaves an exactly zero residue. The bench therefore predicts every outcome from its own bit-serial CRC model, with no knowledge of the pipeline's internal terms. Table-driven blocks are sent back to back, each opened by a clear on its first word. Directed runs then cover a start after reset with no clear, a clear on an idle cycle, gaps carrying garbage data, corrupted data words, and consecutive checksum-only blocks. Together these run R3's two-cycle pulse timing against every other cycle.

// File: rtl/crc_rx_pkg.sv
package crc_rx_pkg;

  // widest word the shared arithmetic supports
  localparam int MAX_W = 32;

  // what the second stage does with the state this cycle
  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_PRESET  = 2'd1,
    ACT_FOLD    = 2'd2,
    ACT_RESTART = 2'd3
  } fold_act_e;

  function automatic fold_act_e pick_act(input logic pend, input logic pclr);
    case ({pend, pclr})
      2'b10:   return ACT_FOLD;
      2'b11:   return ACT_RESTART;
      2'b01:   return ACT_PRESET;
      default: return ACT_HOLD;
    endcase
  endfunction

  // (x * X^w) mod (X^w + poly), for polynomials of degree w <= MAX_W
  function automatic logic [MAX_W-1:0] mul_xw(input logic [MAX_W-1:0] x,
                                               input logic [MAX_W-1:0] poly,
                                               input int w);
    logic [MAX_W-1:0] mask;
    logic [MAX_W-1:0] r;
    logic             top;
    mask = '1;
    if (w < MAX_W) mask = ({{(MAX_W-1){1'b0}}, 1'b1} << w) - 1'b1;
    r = x & mask;
    for (int i = 0; i < w; i++) begin
      top = r[w-1];
      r   = (r << 1) & mask;
      if (top) r = r ^ poly;
    end
    return r;
  endfunction

endpackage

// File: rtl/crc_rx_partial.sv
// First stage: the word-only CRC term plus the control flags that travel with it.
module crc_rx_partial
  import crc_rx_pkg::*;
#(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_vld,
  input  logic [W-1:0] word,
  input  logic         word_end,
  input  logic         clr,
  output logic [W-1:0] part_q,
  output logic         pend_q,
  output logic         pclr_q,
  output logic         pend_end_q
);

  logic [MAX_W-1:0] prod;
  logic [W-1:0]     part_d;

  always_comb begin
    prod   = mul_xw(MAX_W'(word), MAX_W'(POLY), W);
    part_d = prod[W-1:0];
  end

  // the data term is formed every cycle; the pending flag decides if it is used
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q     <= '0;
      pend_q     <= 1'b0;
      pclr_q     <= 1'b0;
      pend_end_q <= 1'b0;
    end else begin
      part_q     <= part_d;
      pend_q     <= word_vld;
      pclr_q     <= clr;
      pend_end_q <= word_vld && word_end;
    end
  end

endmodule

// File: rtl/crc_rx_fold.sv
// Second stage: combines the pending data term with the running state.
module crc_rx_fold
  import crc_rx_pkg::*;
#(
  parameter int           W      = 16,
  parameter logic [W-1:0] POLY   = 16'h1021,
  parameter logic [W-1:0] PRESET = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pend,
  input  logic         pclr,
  input  logic [W-1:0] part,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_nxt
);

  // contribution of a preset state, used when a clear coincides with a word
  localparam logic [MAX_W-1:0] RESTART_W = mul_xw(MAX_W'(PRESET), MAX_W'(POLY), W);
  localparam logic [W-1:0]     RESTART   = RESTART_W[W-1:0];

  fold_act_e        act;
  logic [MAX_W-1:0] shifted_w;
  logic [W-1:0]     folded;

  always_comb begin
    act       = pick_act(pend, pclr);
    shifted_w = mul_xw(MAX_W'(state_q), MAX_W'(POLY), W);
    folded    = shifted_w[W-1:0] ^ part;
    case (act)
      ACT_FOLD:    state_nxt = folded;
      ACT_RESTART: state_nxt = RESTART ^ part;
      ACT_PRESET:  state_nxt = PRESET;
      default:     state_nxt = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PRESET;
    else        state_q <= state_nxt;
  end

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !pclr) |=> $stable(state_q));

  // R5
  clear_alone_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && pclr) |=> (state_q == PRESET));

endmodule

// File: rtl/crc_rx_flag.sv
// Registers the residue test for the block that just ended.
module crc_rx_flag #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] residue,
  output logic         err_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= fire && (residue != '0);
  end

  // R3
  quiet_between_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !err_q);

endmodule

// File: rtl/crc_rx_checker.sv
module crc_rx_checker #(
  parameter int           W      = 16,       // word and CRC width, at most 32
  parameter logic [W-1:0] POLY   = 16'h1021, // generator without its top term
  parameter logic [W-1:0] PRESET = 16'hFFFF  // start value of each block
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk_clr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         err_o
);

  logic [W-1:0] part_q;
  logic         pend_q;
  logic         pclr_q;
  logic         pend_end_q;
  logic [W-1:0] state_q;
  logic [W-1:0] state_nxt;

  // no back-pressure: every valid word is taken
  assign in_ready = 1'b1;

  crc_rx_partial #(.W(W), .POLY(POLY)) u_partial (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (in_valid),
    .word       (in_data),
    .word_end   (in_last),
    .clr        (blk_clr),
    .part_q     (part_q),
    .pend_q     (pend_q),
    .pclr_q     (pclr_q),
    .pend_end_q (pend_end_q)
  );

  crc_rx_fold #(.W(W), .POLY(POLY), .PRESET(PRESET)) u_fold (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_q),
    .pclr      (pclr_q),
    .part      (part_q),
    .state_q   (state_q),
    .state_nxt (state_nxt)
  );

  crc_rx_flag #(.W(W)) u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (pend_end_q),
    .residue (state_nxt),
    .err_q   (err_o)
  );

  // R3
  err_two_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(in_valid && in_last, 2));

  // R8
  ready_always_chk: assert property (@(posedge clk) in_ready);

endmodule

// File: tb/crc_rx_checker_tb_top.sv
`timescale 1ns/1ps
module crc_rx_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_clr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        err_o;

  logic exp_drv = 1'b0;
  logic p0, p1;
  logic chk_en = 1'b0;
  logic done = 1'b0;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk; // 50 MHz

  crc_rx_checker dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .blk_clr  (blk_clr),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .err_o    (err_o)
  );

  // table: up to four data words, count, checksum flip mask
  localparam logic [63:0] TB_DAT [8] = '{
    64'h1234_0000_0000_0000, 64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0000,
    64'hA5A5_5A5A_0F0F_0000, 64'h0001_0002_0003_0004, 64'h8000_7FFF_0000_0000,
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF };
  localparam int TB_LEN [8] = '{1, 4, 2, 3, 4, 2, 0, 4};
  localparam logic [15:0] TB_FLIP [8] = '{
    16'h0000, 16'h0000, 16'h0000, 16'h0001,
    16'h8000, 16'h00F0, 16'h0000, 16'hA5A5 };

  // bench model of the bit-serial CRC (R1)
  function automatic logic [15:0] crc_word(input logic [15:0] s, input logic [15:0] w);
    logic [15:0] r;
    logic        fb;
    r = s;
    for (int i = 15; i >= 0; i--) begin
      fb = r[15] ^ w[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // expected pulse, two cycles after an accepted checksum word (R3)
  always @(posedge clk) begin
    if (!rst_n) begin
      p0 <= 1'b0;
      p1 <= 1'b0;
    end else begin
      p0 <= in_valid && in_last && exp_drv;
      p1 <= p0;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (err_o !== p1) begin
        errors++;
        $display("FAIL R3 R2 R10 err_o actual=%b expected=%b at %0t", err_o, p1, $time);
      end
    end
  end

  task automatic check(input logic cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] d, input logic last, input logic clr,
                     input logic exp);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_last  = last;
    blk_clr  = clr;
    exp_drv  = exp;
  endtask

  // idle cycles carrying garbage, with in_last high (R7)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 16'hBAD0 ^ 16'(i * 16'h1357);
      in_last  = 1'b1;
      blk_clr  = 1'b0;
      exp_drv  = 1'b1;
    end
  endtask

  task automatic send_block(input logic [63:0] dat, input int n, input logic [15:0] flip,
                            input logic clr);
    logic [15:0] s;
    logic [15:0] w;
    s = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      w = dat[63-16*i -: 16];
      put(w, 1'b0, clr && (i == 0), 1'b0);
      s = crc_word(s, w);
    end
    put(s ^ flip, 1'b1, clr && (n == 0), flip != 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    // reset state (R9, R8)
    repeat (3) @(negedge clk);
    check(err_o === 1'b0, "R9 err_o in reset", 32'(err_o), 0);
    check(in_ready === 1'b1, "R8 in_ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    chk_en = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R8 in_ready after reset", 32'(in_ready), 1);

    // R9: first block after reset, no clear
    send_block(64'h4242_1111_0000_0000, 2, 16'h0000, 1'b0);
    idle(3);

    // R2 R4 R10: table walked back to back, clear on each first word
    for (int k = 0; k < 8; k++)
      send_block(TB_DAT[k], TB_LEN[k], TB_FLIP[k], 1'b1);
    idle(3);

    // R5: abandoned block, then a clear alone, then a block without clear
    put(16'h7777, 1'b0, 1'b1, 1'b0);
    put(16'h3333, 1'b0, 1'b0, 1'b0);
    idle(2);
    @(negedge clk);
    in_valid = 1'b0; blk_clr = 1'b1; in_last = 1'b0; exp_drv = 1'b0;
    send_block(64'h0BAD_F00D_0000_0000, 2, 16'h0000, 1'b0);
    idle(2);

    // R6 R7: gaps with garbage inside a clean block and a corrupted one
    for (int c = 0; c < 2; c++) begin
      s = crc_word(crc_word(16'hFFFF, 16'h1357), 16'h2468);
      put(16'h1357, 1'b0, 1'b1, 1'b0);
      idle(3);
      put(16'h2468, 1'b0, 1'b0, 1'b0);
      idle(2);
      put(s ^ 16'(c * 16'h0400), 1'b1, 1'b0, c != 0);
    end
    idle(3);

    // R10: two-bit corruption of a data word, checksum of the original
    s = crc_word(crc_word(16'hFFFF, 16'h5555), 16'h6666);
    put(16'h5555, 1'b0, 1'b1, 1'b0);
    put(16'h6666 ^ 16'h0081, 1'b0, 1'b0, 1'b0);
    put(s, 1'b1, 1'b0, 1'b1);
    idle(2);

    // R3: checksum-only blocks on consecutive cycles
    send_block(64'h0, 0, 16'h0000, 1'b1);
    send_block(64'h0, 0, 16'h0100, 1'b1);
    send_block(64'h0, 0, 16'h0300, 1'b1);
    send_block(64'h0, 0, 16'h0000, 1'b1);
    idle(5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule